// File: doc/BRIEF.md
# SD Card Presence Monitor

This block supervises the two active-low mechanical switches of an SD socket: the card-detect switch and the write-protect switch. Both pins are brought into the clock domain through a two-stage synchronizer. The card-detect level is then debounced by a counter, `DEBOUNCE_CYCLES` clocks long. The block reports the raw detect level, a settled flag, a debounced card-present flag and a write-allowed flag.

Each debounced insertion raises a single-cycle interrupt pulse, and so does each debounced removal. The block also holds the enables for SD bus power and for the SD clock. Software sets and clears them through strobe inputs. If a card is pulled out while both enables are on, the block drops both enables by itself.

There are two resets. A power-on reset clears everything. The controller-wide soft reset only returns the two enables to off, so the presence state survives a software recovery.

Top module: `cd_monitor`

## Requirements
- R1: `cd_level` is the inverse of `cd_pin_n`, delayed by the two synchronizer flops: a pin change made before clock edge n appears after edge n+1. A value of 1 means a card is present (pin low).
- R2: `wr_enabled` is the inverse of `wp_pin_n`, with the same two-edge delay as R1. A value of 1 means writes are allowed (pin low).
- R3: `cd_stable` is 0 after power-on reset, and it drops to 0 on the edge that sees a change in the synchronized detect level. It returns to 1 only after `DEBOUNCE_CYCLES` further consecutive edges with no change. This holds for both the card-present and the card-absent level.
- R4: `card_inserted` is 1 only while `cd_stable` is 1 and the debounced level says a card is present. Detection does not depend on the state of bus power.
- R5: `irq_insert` pulses high for exactly one cycle when `card_inserted` goes from 0 to 1.
- R6: `irq_remove` pulses high for exactly one cycle when `card_inserted` goes from 1 to 0.
- R7: If `irq_remove` is high while both `bus_pwr_en` and `sd_clk_en` are 1, both enables are 0 after the next edge. This takes priority over a software set in the same cycle.
- R8: A removal that happens while either enable is already off leaves both enables unchanged.
- R9: A set strobe turns its enable on at the next edge. A clear strobe turns it off, and the clear wins when set and clear are given together.
- R10: A low `srst_all_n` at an edge turns both enables off. It leaves `cd_stable`, `card_inserted` and the interrupt outputs unaffected.
- R11: While `por_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset, synchronous, active low, clears all state |
| srst_all_n | input | 1 | Controller soft reset, synchronous, active low, clears only the enables |
| cd_pin_n | input | 1 | Card-detect switch, low when a card is seated |
| wp_pin_n | input | 1 | Write-protect switch, low when writes are allowed |
| pwr_set | input | 1 | Strobe: turn bus power on |
| pwr_clr | input | 1 | Strobe: turn bus power off |
| clk_set | input | 1 | Strobe: turn SD clock on |
| clk_clr | input | 1 | Strobe: turn SD clock off |
| cd_level | output | 1 | Synchronized, inverted detect pin level |
| cd_stable | output | 1 | Detect level has settled |
| card_inserted | output | 1 | Debounced card present |
| wr_enabled | output | 1 | Synchronized, inverted write-protect pin level |
| irq_insert | output | 1 | One-cycle insertion pulse |
| irq_remove | output | 1 | One-cycle removal pulse |
| bus_pwr_en | output | 1 | SD bus power enable |
| sd_clk_en | output | 1 | SD clock enable |

## Verification
The assertions assume that the set and clear strobes are levels sampled at each edge, and that `por_n` is held low for at least one edge before any check counts. They also assume the pins may change at any cycle, glitches included. The stimulus changes every input only on the falling clock edge and starts with several reset edges. It drives bounces and single-cycle glitches that are shorter than the debounce window, as well as clean holds that are longer than it. Removals are performed once with both enables on and a software set held, and once with the clock off, so both branches of the hot-removal rule are exercised.

// File: rtl/cdm_pkg.sv
`timescale 1ns/1ps
// Shared constants for the card presence monitor.
// Channel indices select the enable bits held by cdm_enable_ctl.
package cdm_pkg;
    localparam int unsigned CH_PWR = 0;   // SD bus power enable
    localparam int unsigned CH_CLK = 1;   // SD clock enable
    localparam int unsigned NUM_CH = 2;
    // Index of each pin inside the synchronizer vector
    localparam int unsigned PIN_CD = 0;
    localparam int unsigned PIN_WP = 1;
    localparam int unsigned NUM_PINS = 2;
endpackage

// File: rtl/cdm_sync2.sv
`timescale 1ns/1ps
// Two-flop synchronizer for a vector of asynchronous pins.
// Assumes each bit is independent; no bus coherency is implied.
// Reset value is the idle level of the pins (all ones for active-low switches).
module cdm_sync2 #(
    parameter int unsigned WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic meta_q;
        logic sync_q;
        // Two capture stages per pin bit
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= 1'b1;
                sync_q <= 1'b1;
            end else begin
                meta_q <= d_i[b];
                sync_q <= meta_q;
            end
        end
        assign q_o[b] = sync_q;
    end
endmodule

// File: rtl/cdm_debounce.sv
`timescale 1ns/1ps
// Debounce counter for the synchronized card-detect level.
// Assumes lvl_i is already synchronous. Any change of lvl_i restarts the
// count and clears stable_o; stable_o rises after DEBOUNCE_CYCLES unchanged edges.
module cdm_debounce #(
    parameter int unsigned DEBOUNCE_CYCLES = 65536
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic lvl_o,
    output logic stable_o
);
    localparam int unsigned CNT_W = (DEBOUNCE_CYCLES > 2) ? $clog2(DEBOUNCE_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEBOUNCE_CYCLES - 1);

    logic             lvl_q;
    logic [CNT_W-1:0] cnt_q;
    logic             stable_q;

    // Track the level, restart on change, count up to the settle point
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q    <= 1'b1;
            cnt_q    <= '0;
            stable_q <= 1'b0;
        end else if (lvl_i != lvl_q) begin
            lvl_q    <= lvl_i;
            cnt_q    <= '0;
            stable_q <= 1'b0;
        end else if (!stable_q) begin
            if (cnt_q == CNT_LAST) begin
                stable_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign lvl_o    = lvl_q;
    assign stable_o = stable_q;

    // A level change must knock the stable flag down on the next edge
    assert_change_drops_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_i != lvl_q) |=> !stable_o);

    // Stable can only rise on an edge where the held level did not move
    assert_rise_needs_steady_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stable_o) |-> $stable(lvl_o));
endmodule

// File: rtl/cdm_enable_ctl.sv
`timescale 1ns/1ps
// Holds the bus power and SD clock enables.
// Assumes set/clear are level strobes sampled each edge. Priority, highest
// first: power-on reset, soft reset, hot-removal clear, clear strobe, set strobe.
module cdm_enable_ctl #(
    parameter int unsigned NUM_CH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              srst_n,
    input  logic              hot_i,
    input  logic [NUM_CH-1:0] set_i,
    input  logic [NUM_CH-1:0] clr_i,
    output logic [NUM_CH-1:0] en_o
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic en_q;
        // One enable bit with prioritised clear sources
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                en_q <= 1'b0;
            end else if (!srst_n || hot_i) begin
                en_q <= 1'b0;
            end else if (clr_i[c]) begin
                en_q <= 1'b0;
            end else if (set_i[c]) begin
                en_q <= 1'b1;
            end
        end
        assign en_o[c] = en_q;

        // A lone set strobe outside any clear source turns the bit on
        assert_set_takes_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (srst_n && !hot_i && set_i[c] && !clr_i[c]) |=> en_o[c]);

        // A clear strobe always wins over a set strobe
        assert_clear_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
            clr_i[c] |=> !en_o[c]);
    end

    // Hot removal empties every enable on the following edge
    assert_hot_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hot_i |=> (en_o == '0));

    // Soft reset empties every enable on the following edge
    assert_soft_reset_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !srst_n |=> (en_o == '0));
endmodule

// File: rtl/cd_monitor.sv
`timescale 1ns/1ps
// SD socket presence monitor: synchronizes the detect and write-protect
// switches, debounces detect, raises insertion/removal pulses and shuts
// power and clock down on a hot removal. Only por_n touches presence state;
// srst_all_n reaches the enable registers alone.
module cd_monitor #(
    parameter int unsigned DEBOUNCE_CYCLES = 65536
) (
    input  logic clk,
    input  logic por_n,
    input  logic srst_all_n,
    input  logic cd_pin_n,
    input  logic wp_pin_n,
    input  logic pwr_set,
    input  logic pwr_clr,
    input  logic clk_set,
    input  logic clk_clr,
    output logic cd_level,
    output logic cd_stable,
    output logic card_inserted,
    output logic wr_enabled,
    output logic irq_insert,
    output logic irq_remove,
    output logic bus_pwr_en,
    output logic sd_clk_en
);
    import cdm_pkg::*;

    logic [NUM_PINS-1:0] pins_raw;
    logic [NUM_PINS-1:0] pins_sync;
    logic                db_lvl;
    logic                db_stable;
    logic                present;
    logic                present_prev_q;
    logic                hot_removal;
    logic [NUM_CH-1:0]   en_set;
    logic [NUM_CH-1:0]   en_clr;
    logic [NUM_CH-1:0]   en_q;

    // Gather both pins into one synchronizer vector
    always_comb begin
        pins_raw         = '1;
        pins_raw[PIN_CD] = cd_pin_n;
        pins_raw[PIN_WP] = wp_pin_n;
    end

    cdm_sync2 #(.WIDTH(NUM_PINS)) u_sync (
        .clk   (clk),
        .rst_n (por_n),
        .d_i   (pins_raw),
        .q_o   (pins_sync)
    );

    cdm_debounce #(.DEBOUNCE_CYCLES(DEBOUNCE_CYCLES)) u_debounce (
        .clk      (clk),
        .rst_n    (por_n),
        .lvl_i    (pins_sync[PIN_CD]),
        .lvl_o    (db_lvl),
        .stable_o (db_stable)
    );

    // Present only once settled on the card-seated (low) level
    assign present = db_stable & ~db_lvl;

    // Remember last cycle's presence for edge pulses
    always_ff @(posedge clk) begin
        if (!por_n) begin
            present_prev_q <= 1'b0;
        end else begin
            present_prev_q <= present;
        end
    end

    // Route strobes to their channels
    always_comb begin
        en_set         = '0;
        en_clr         = '0;
        en_set[CH_PWR] = pwr_set;
        en_set[CH_CLK] = clk_set;
        en_clr[CH_PWR] = pwr_clr;
        en_clr[CH_CLK] = clk_clr;
    end

    assign irq_insert  = present & ~present_prev_q;
    assign irq_remove  = present_prev_q & ~present;
    assign hot_removal = irq_remove & en_q[CH_PWR] & en_q[CH_CLK];

    cdm_enable_ctl #(.NUM_CH(NUM_CH)) u_enables (
        .clk    (clk),
        .rst_n  (por_n),
        .srst_n (srst_all_n),
        .hot_i  (hot_removal),
        .set_i  (en_set),
        .clr_i  (en_clr),
        .en_o   (en_q)
    );

    assign cd_level      = ~pins_sync[PIN_CD];
    assign wr_enabled    = ~pins_sync[PIN_WP];
    assign cd_stable     = db_stable;
    assign card_inserted = present;
    assign bus_pwr_en    = en_q[CH_PWR];
    assign sd_clk_en     = en_q[CH_CLK];

    // Insertion pulse lasts one cycle only
    assert_insert_single_R5: assert property (@(posedge clk) disable iff (!por_n)
        irq_insert |=> !irq_insert);

    // Removal pulse lasts one cycle only
    assert_remove_single_R6: assert property (@(posedge clk) disable iff (!por_n)
        irq_remove |=> !irq_remove);

    // An insertion is only announced from a settled level
    assert_insert_from_stable_R4: assert property (@(posedge clk) disable iff (!por_n)
        irq_insert |-> cd_stable);

    // Removal with either enable off leaves the enables alone
    assert_cold_removal_keeps_R8: assert property (@(posedge clk) disable iff (!por_n)
        (irq_remove && !(bus_pwr_en && sd_clk_en) && srst_all_n
         && !pwr_set && !pwr_clr && !clk_set && !clk_clr)
        |=> ($stable(bus_pwr_en) && $stable(sd_clk_en)));
endmodule

// File: tb/sim_cd_monitor.sv
`timescale 1ns/1ps
module sim_cd_monitor;
    localparam int DB = 16;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic por_n = 1'b0, srst_all_n = 1'b1, cd_pin_n = 1'b1, wp_pin_n = 1'b1;
    logic pwr_set = 1'b0, pwr_clr = 1'b0, clk_set = 1'b0, clk_clr = 1'b0;
    logic cd_level, cd_stable, card_inserted, wr_enabled;
    logic irq_insert, irq_remove, bus_pwr_en, sd_clk_en;

    cd_monitor #(.DEBOUNCE_CYCLES(DB)) u0 (
        .clk(clk), .por_n(por_n), .srst_all_n(srst_all_n),
        .cd_pin_n(cd_pin_n), .wp_pin_n(wp_pin_n),
        .pwr_set(pwr_set), .pwr_clr(pwr_clr), .clk_set(clk_set), .clk_clr(clk_clr),
        .cd_level(cd_level), .cd_stable(cd_stable), .card_inserted(card_inserted),
        .wr_enabled(wr_enabled), .irq_insert(irq_insert), .irq_remove(irq_remove),
        .bus_pwr_en(bus_pwr_en), .sd_clk_en(sd_clk_en)
    );

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 0;

    // Behavioural reference: pin history, run length, expected outputs
    bit pin_hist [$];
    bit wp_hist  [$];
    int run_len;
    bit m_stab, m_ins, m_irq_i, m_irq_r, m_pwr, m_clk;

    always @(posedge clk) begin
        bit was_ins, hot, cur_s, old_s;
        if (!por_n) begin
            pin_hist = '{1'b1, 1'b1, 1'b1};
            wp_hist  = '{1'b1, 1'b1};
            run_len = 0; m_stab = 0; m_ins = 0; m_irq_i = 0; m_irq_r = 0;
            m_pwr = 0; m_clk = 0;
        end else begin
            hot   = m_irq_r && m_pwr && m_clk;
            cur_s = pin_hist[1];   // level reaching the debouncer this edge
            old_s = pin_hist[2];   // level it held before
            if (cur_s != old_s) begin
                run_len = 0; m_stab = 0;
            end else if (!m_stab) begin
                run_len++;
                if (run_len >= DB) m_stab = 1;
            end
            pin_hist.push_front(cd_pin_n); void'(pin_hist.pop_back());
            wp_hist.push_front(wp_pin_n);  void'(wp_hist.pop_back());
            was_ins = m_ins;
            m_ins   = m_stab && !pin_hist[2];
            m_irq_i = m_ins && !was_ins;
            m_irq_r = was_ins && !m_ins;
            if (!srst_all_n || hot) begin
                m_pwr = 0; m_clk = 0;
            end else begin
                if (pwr_clr) m_pwr = 0; else if (pwr_set) m_pwr = 1;
                if (clk_clr) m_clk = 0; else if (clk_set) m_clk = 1;
            end
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    // Advance to the next falling edge and compare every output with the model
    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk("R1 cd_level",      cd_level,      !pin_hist[1]);
            chk("R2 wr_enabled",    wr_enabled,    !wp_hist[1]);
            chk("R3 cd_stable",     cd_stable,     m_stab);
            chk("R4 card_inserted", card_inserted, m_ins);
            chk("R5 irq_insert",    irq_insert,    m_irq_i);
            chk("R6 irq_remove",    irq_remove,    m_irq_r);
            chk("R9 bus_pwr_en",    bus_pwr_en,    m_pwr);
            chk("R9 sd_clk_en",     sd_clk_en,     m_clk);
        end
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        // R11: everything low while power-on reset is held
        step(3);
        chk("R11 reset outputs", cd_level | cd_stable | card_inserted | wr_enabled |
            irq_insert | irq_remove | bus_pwr_en | sd_clk_en, 1'b0);
        por_n = 1'b1;
        step(DB + 8);
        chk("R3 settles with no card", cd_stable, 1'b1);
        chk("R4 no card reported", card_inserted, 1'b0);

        // R9: set strobes, then clear beating set
        pwr_set = 1; clk_set = 1; step(1); pwr_set = 0; clk_set = 0;
        chk("R9 power set", bus_pwr_en, 1'b1);
        chk("R9 clock set", sd_clk_en, 1'b1);
        pwr_set = 1; pwr_clr = 1; step(1); pwr_set = 0; pwr_clr = 0;
        chk("R9 clear wins", bus_pwr_en, 1'b0);

        // R3/R4: insertion with power off, bouncing first
        for (int k = 0; k < 4; k++) begin
            cd_pin_n = k[0]; step(3);
        end
        chk("R3 unstable while bouncing", cd_stable, 1'b0);
        cd_pin_n = 1; step(4);
        cd_pin_n = 0; step(1);
        chk("R1 one edge not yet visible", cd_level, 1'b0);
        step(1);
        chk("R1 visible after two edges", cd_level, 1'b1);
        for (int i = 0; i < 60 && !irq_insert; i++) step(1);
        chk("R5 insertion pulse", irq_insert, 1'b1);
        chk("R4 inserted with power off", card_inserted, 1'b1);
        step(1);
        chk("R5 pulse is single", irq_insert, 1'b0);

        // R2: write-protect pin
        wp_pin_n = 0; step(2);
        chk("R2 write allowed", wr_enabled, 1'b1);
        wp_pin_n = 1; step(2);
        chk("R2 write protected", wr_enabled, 1'b0);

        // R10: soft reset drops enables, keeps presence
        pwr_set = 1; clk_set = 1; step(1); pwr_set = 0; clk_set = 0;
        srst_all_n = 0; step(1); srst_all_n = 1;
        chk("R10 power off", bus_pwr_en, 1'b0);
        chk("R10 clock off", sd_clk_en, 1'b0);
        chk("R10 stable kept", cd_stable, 1'b1);
        chk("R10 inserted kept", card_inserted, 1'b1);
        step(3);

        // R6/R7: hot removal with a software set held
        pwr_set = 1; clk_set = 1; step(1); clk_set = 0;
        cd_pin_n = 1;
        for (int i = 0; i < 10 && !irq_remove; i++) step(1);
        chk("R6 removal pulse", irq_remove, 1'b1);
        chk("R7 enables on before clear", bus_pwr_en & sd_clk_en, 1'b1);
        step(1);
        chk("R7 power cleared over set", bus_pwr_en, 1'b0);
        chk("R7 clock cleared", sd_clk_en, 1'b0);
        chk("R6 pulse is single", irq_remove, 1'b0);
        pwr_set = 0; step(DB + 6);

        // R8: removal with clock off keeps power
        cd_pin_n = 0;
        for (int i = 0; i < 60 && !irq_insert; i++) step(1);
        pwr_set = 1; step(1); pwr_set = 0;
        cd_pin_n = 1;
        for (int i = 0; i < 10 && !irq_remove; i++) step(1);
        chk("R6 second removal pulse", irq_remove, 1'b1);
        step(2);
        chk("R8 power kept with clock off", bus_pwr_en, 1'b1);
        pwr_clr = 1; step(1); pwr_clr = 0;
        step(DB + 6);

        // R3: single-cycle glitch restarts the window, no insertion
        cd_pin_n = 0; step(1); cd_pin_n = 1; step(3);
        chk("R3 glitch clears stable", cd_stable, 1'b0);
        chk("R4 glitch not inserted", card_inserted, 1'b0);
        step(DB + 4);
        chk("R3 re-settles on no card", cd_stable, 1'b1);

        done = 1;
        summary();
        $finish;
    end
endmodule